// File: doc/BRIEF.md
# Microcoded Accumulator CPU

This block is an 8-bit processor with a single accumulator, a program counter, an operand register and a hidden opcode register. All four share one internal byte-wide bus. A microcode sequencer steps through a fixed list of micro-steps for each instruction. In every micro-step it raises a set of named control lines, and those lines select what drives the bus and which registers capture it. Main memory lies outside the block and is reached through an address port, a read-data input, a write-data output and a write strobe. The memory read path is combinational.

Every instruction is two bytes long: an opcode byte followed by an operand byte. Four fetch micro-steps run first. They capture the opcode, advance the PC, capture the operand into the instruction register and advance the PC again. One or two execute micro-steps follow. The instruction set has seven opcodes:

- load from memory
- store to memory
- increment
- decrement
- unconditional jump
- jump when the accumulator is zero
- halt

The conditional jump has no flag register. A dedicated check line lets the PC take the bus value only when the NOR of all accumulator bits is true. Halt takes two micro-steps. The first shows the accumulator on the bus. The second raises the stop line, which freezes the machine until reset.

A step-mode input lets a debugger advance the machine one micro-step per pulse. Debug outputs expose the registers, the bus and the current control lines.

Top module: `accu_cpu`

## Requirements
- R1: After reset the PC, accumulator and halted flag are zero, and the machine waits in the first fetch micro-step with `memAddr` equal to 0.
- R2: Each instruction begins with four fetch micro-steps. Opcode capture leaves the PC unchanged, the second step adds 1, operand capture leaves it unchanged, and the fourth step adds 1 again. A valid non-halt instruction takes 5 micro-steps in total.
- R3: Opcode 10h loads the accumulator with the memory byte at the operand address.
- R4: Opcode 20h writes the accumulator to the operand address, with `memWr` high for exactly one micro-step and `memWrData` equal to the accumulator.
- R5: Opcode 30h adds one to the accumulator and opcode 40h subtracts one, both modulo 256 (FFh+1 gives 00h and 00h-1 gives FFh).
- R6: Opcode 50h loads the PC with the operand, so the next opcode fetch reads the target address.
- R7: Opcode 60h loads the PC with the operand only when the accumulator is 00h. Otherwise the PC keeps the address of the following instruction.
- R8: Opcode 70h spends its first execute micro-step with the accumulator on `dbgBus`. In its second step it sets `halted`. After that the PC, accumulator and memory stay frozen until reset, so a halt instruction takes 6 micro-steps.
- R9: Any opcode byte other than the seven above is a no-operation. It uses only the 4 fetch micro-steps and changes no register except the PC.
- R10: With `stepMode` high, the machine advances exactly one micro-step for each clock cycle in which `stepPulse` is high, and holds all state otherwise. With `stepMode` low it advances one micro-step per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stepMode | input | 1 | High selects single-step operation |
| stepPulse | input | 1 | Advance enable while in step mode |
| memAddr | output | ADDR_W | Memory address (PC, or the operand for load/store) |
| memRdData | input | DATA_W | Combinational read data from memory |
| memWrData | output | DATA_W | Write data (bus value) |
| memWr | output | 1 | Memory write strobe, one cycle per store |
| halted | output | 1 | Set by the stop micro-step, cleared by reset |
| dbgPc | output | ADDR_W | Program counter |
| dbgAcc | output | DATA_W | Accumulator |
| dbgIr | output | DATA_W | Instruction (operand) register |
| dbgBus | output | DATA_W | Internal bus value |
| dbgCtrl | output | CTRL_W | Control lines of the current micro-step |

## Verification
The bench builds the block with both widths at 8. This opens the whole 256-byte address space and lets the accumulator wrap at FFh and 00h. Random two-byte programs keep their data in the upper half of memory and use forward-only jumps, so each one ends at a halt. A bench instruction model supplies the expected final accumulator, PC, data bytes and micro-step count for each program. Directed runs cover single-stepping through fetch and halt, wrap in both directions, a taken and an untaken zero-jump, and an unknown opcode.

// File: rtl/accu_cpu_pkg.sv
package accu_cpu_pkg;

  // Opcode bytes; decode is on the full byte.
  localparam logic [7:0] OP_LOAD  = 8'h10;
  localparam logic [7:0] OP_STORE = 8'h20;
  localparam logic [7:0] OP_INC   = 8'h30;
  localparam logic [7:0] OP_DEC   = 8'h40;
  localparam logic [7:0] OP_JUMP  = 8'h50;
  localparam logic [7:0] OP_JZERO = 8'h60;
  localparam logic [7:0] OP_HALT  = 8'h70;

  // Micro-step index: fetch steps then execute steps named by opcode digit and step.
  typedef enum logic [3:0] {
    S_F0  = 4'd0,
    S_F1  = 4'd1,
    S_F2  = 4'd2,
    S_F3  = 4'd3,
    S_X11 = 4'd4,
    S_X21 = 4'd5,
    S_X31 = 4'd6,
    S_X41 = 4'd7,
    S_X51 = 4'd8,
    S_X61 = 4'd9,
    S_X71 = 4'd10,
    S_X72 = 4'd11
  } uStep_t;

  // Control lines raised by one micro-step.
  typedef struct packed {
    logic memToBus;
    logic accToBus;
    logic irToBus;
    logic addrFromIr;
    logic opLoad;
    logic irLoad;
    logic accLoad;
    logic accUp;
    logic accDn;
    logic pcInc;
    logic pcLoad;
    logic pcCheck;
    logic memWrite;
    logic stop;
  } ctrlLines_t;

  localparam int CTRL_W = $bits(ctrlLines_t);

endpackage

// File: rtl/accu_cpu_ctrl.sv
module accu_cpu_ctrl
  import accu_cpu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stepMode,
  input  logic              stepPulse,
  input  logic [DATA_W-1:0] opcode,
  output ctrlLines_t        lines,
  output logic              advance,
  output logic              halted
);

  uStep_t step, stepNext;

  assign advance = !halted && (!stepMode || stepPulse);

  // Dispatch after the last fetch step on the full opcode byte.
  function automatic uStep_t dispatch(input logic [DATA_W-1:0] op);
    uStep_t s;
    if      (op == DATA_W'(OP_LOAD))  s = S_X11;
    else if (op == DATA_W'(OP_STORE)) s = S_X21;
    else if (op == DATA_W'(OP_INC))   s = S_X31;
    else if (op == DATA_W'(OP_DEC))   s = S_X41;
    else if (op == DATA_W'(OP_JUMP))  s = S_X51;
    else if (op == DATA_W'(OP_JZERO)) s = S_X61;
    else if (op == DATA_W'(OP_HALT))  s = S_X71;
    else                              s = S_F0;
    return s;
  endfunction

  always_comb begin
    case (step)
      S_F0:    stepNext = S_F1;
      S_F1:    stepNext = S_F2;
      S_F2:    stepNext = S_F3;
      S_F3:    stepNext = dispatch(opcode);
      S_X71:   stepNext = S_X72;
      default: stepNext = S_F0;
    endcase
  end

  // Microcode: control lines for each micro-step.
  always_comb begin
    lines = '0;
    case (step)
      S_F0: begin lines.memToBus = 1'b1; lines.opLoad = 1'b1; end
      S_F1: lines.pcInc = 1'b1;
      S_F2: begin lines.memToBus = 1'b1; lines.irLoad = 1'b1; end
      S_F3: lines.pcInc = 1'b1;
      S_X11: begin
        lines.addrFromIr = 1'b1;
        lines.memToBus   = 1'b1;
        lines.accLoad    = 1'b1;
      end
      S_X21: begin
        lines.addrFromIr = 1'b1;
        lines.accToBus   = 1'b1;
        lines.memWrite   = 1'b1;
      end
      S_X31: lines.accUp = 1'b1;
      S_X41: lines.accDn = 1'b1;
      S_X51: begin lines.irToBus = 1'b1; lines.pcLoad = 1'b1; end
      S_X61: begin lines.irToBus = 1'b1; lines.pcCheck = 1'b1; end
      S_X71: lines.accToBus = 1'b1;
      S_X72: lines.stop = 1'b1;
      default: lines = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step   <= S_F0;
      halted <= 1'b0;
    end else if (advance) begin
      step <= stepNext;
      if (lines.stop) halted <= 1'b1;
    end
  end

  // R8
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  // R10
  step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stepMode && !stepPulse) |=> $stable(step));

  // R8
  stop_sets_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && step == S_X72) |=> halted);

endmodule

// File: rtl/accu_cpu_dpath.sv
module accu_cpu_dpath
  import accu_cpu_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlLines_t        lines,
  input  logic              advance,
  input  logic [DATA_W-1:0] memRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              memWr,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] acc,
  output logic [DATA_W-1:0] ir,
  output logic [DATA_W-1:0] opReg,
  output logic [DATA_W-1:0] bus
);

  logic accZero;
  logic pcTake;

  // Shared bus: one source at a time per micro-step.
  always_comb begin
    if      (lines.memToBus) bus = memRdData;
    else if (lines.accToBus) bus = acc;
    else if (lines.irToBus)  bus = ir;
    else                     bus = '0;
  end

  assign memAddr   = lines.addrFromIr ? ADDR_W'(ir) : pc;
  assign memWrData = bus;
  assign memWr     = lines.memWrite && advance;

  // Zero detect: NOR across every accumulator bit gates the check line.
  assign accZero = ~|acc;
  assign pcTake  = lines.pcLoad || (lines.pcCheck && accZero);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0;
    end else if (advance) begin
      if (pcTake)           pc <= ADDR_W'(bus);
      else if (lines.pcInc) pc <= pc + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
    end else if (advance) begin
      if (lines.accLoad)    acc <= bus;
      else if (lines.accUp) acc <= acc + 1'b1;
      else if (lines.accDn) acc <= acc - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir    <= '0;
      opReg <= '0;
    end else if (advance) begin
      if (lines.irLoad) ir    <= bus;
      if (lines.opLoad) opReg <= bus;
    end
  end

  // R5
  acc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(advance && (lines.accLoad || lines.accUp || lines.accDn)) |=> $stable(acc));

  // R7
  jz_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && lines.pcCheck && acc != '0) |=> $stable(pc));

  // R2
  pc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(advance && (lines.pcInc || lines.pcLoad || lines.pcCheck)) |=> $stable(pc));

  // R4
  store_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    memWr |-> (memAddr == ADDR_W'(ir)) && (memWrData == acc));

endmodule

// File: rtl/accu_cpu.sv
module accu_cpu
  import accu_cpu_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stepMode,
  input  logic              stepPulse,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memRdData,
  output logic [DATA_W-1:0] memWrData,
  output logic              memWr,
  output logic              halted,
  output logic [ADDR_W-1:0] dbgPc,
  output logic [DATA_W-1:0] dbgAcc,
  output logic [DATA_W-1:0] dbgIr,
  output logic [DATA_W-1:0] dbgBus,
  output logic [CTRL_W-1:0] dbgCtrl
);

  ctrlLines_t        lines;
  logic              advance;
  logic [DATA_W-1:0] opReg;

  accu_cpu_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .stepMode  (stepMode),
    .stepPulse (stepPulse),
    .opcode    (opReg),
    .lines     (lines),
    .advance   (advance),
    .halted    (halted)
  );

  accu_cpu_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .lines     (lines),
    .advance   (advance),
    .memRdData (memRdData),
    .memAddr   (memAddr),
    .memWrData (memWrData),
    .memWr     (memWr),
    .pc        (dbgPc),
    .acc       (dbgAcc),
    .ir        (dbgIr),
    .opReg     (opReg),
    .bus       (dbgBus)
  );

  assign dbgCtrl = lines;

endmodule

// File: tb/accu_cpu_test.sv
`timescale 1ns/1ps
module accu_cpu_test;
  import accu_cpu_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stepMode = 1'b0;
  logic stepPulse = 1'b0;
  logic [7:0] memAddr, memRdData, memWrData;
  logic memWr, halted;
  logic [7:0] dbgPc, dbgAcc, dbgIr, dbgBus;
  logic [CTRL_W-1:0] dbgCtrl;

  logic [7:0] mem    [256];
  logic [7:0] refMem [256];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  accu_cpu uut (
    .clk(clk), .rst_n(rst_n), .stepMode(stepMode), .stepPulse(stepPulse),
    .memAddr(memAddr), .memRdData(memRdData), .memWrData(memWrData),
    .memWr(memWr), .halted(halted), .dbgPc(dbgPc), .dbgAcc(dbgAcc),
    .dbgIr(dbgIr), .dbgBus(dbgBus), .dbgCtrl(dbgCtrl)
  );

  assign memRdData = mem[memAddr];
  always @(posedge clk) if (memWr) mem[memAddr] <= memWrData;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Instruction-level model: final acc, pc, micro-step count and memory image.
  logic [7:0] refAcc, refPc;
  int refSteps;
  task automatic refRun();
    logic [7:0] op, opr;
    refAcc = 0; refPc = 0; refSteps = 0;
    for (int i = 0; i < 2000; i++) begin
      op = refMem[refPc]; opr = refMem[refPc + 8'd1];
      refPc = refPc + 8'd2;
      refSteps += 4;
      case (op)
        8'h10: begin refAcc = refMem[opr]; refSteps += 1; end
        8'h20: begin refMem[opr] = refAcc; refSteps += 1; end
        8'h30: begin refAcc = refAcc + 8'd1; refSteps += 1; end
        8'h40: begin refAcc = refAcc - 8'd1; refSteps += 1; end
        8'h50: begin refPc = opr; refSteps += 1; end
        8'h60: begin if (refAcc == 0) refPc = opr; refSteps += 1; end
        8'h70: begin refSteps += 2; break; end
        default: ;
      endcase
    end
  endtask

  task automatic doReset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic pulse();
    stepPulse = 1'b1;
    @(negedge clk);
    stepPulse = 1'b0;
  endtask

  // Run memory image to halt in run mode and compare with the model.
  task automatic runAndCompare(input string tag);
    int cyc;
    for (int a = 0; a < 256; a++) refMem[a] = mem[a];
    refRun();
    stepMode = 1'b0;
    doReset();
    cyc = 0;
    while (!halted && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
    chk({tag, " R2 micro-step count"}, cyc, refSteps);
    chk({tag, " R3 acc"}, dbgAcc, refAcc);
    chk({tag, " R6 pc"}, dbgPc, refPc);
    for (int a = 128; a < 256; a++)
      if (mem[a] !== refMem[a]) chk({tag, " R4 data byte"}, mem[a], refMem[a]);
    checks++;
    repeat (4) @(negedge clk);
    chk({tag, " R8 frozen pc"}, dbgPc, refPc);
  endtask

  task automatic clearMem();
    for (int a = 0; a < 256; a++) mem[a] = 8'h00;
  endtask

  task automatic buildRandom();
    int n, a, last, k;
    logic [7:0] unk [4];
    unk[0] = 8'h00; unk[1] = 8'h80; unk[2] = 8'h35; unk[3] = 8'hFF;
    clearMem();
    for (int d = 128; d < 256; d++)
      mem[d] = ($urandom % 4 == 0) ? 8'h00 : (($urandom % 4 == 0) ? 8'hFF : 8'($urandom));
    n = 8 + int'($urandom % 13);
    last = (n - 1) * 2;
    a = 0;
    while (a < last) begin
      k = int'($urandom % 8);
      case (k)
        0: begin mem[a] = 8'h10; mem[a+1] = 8'h80 | 8'($urandom % 128); end
        1: begin mem[a] = 8'h20; mem[a+1] = 8'h80 | 8'($urandom % 128); end
        2, 7: begin mem[a] = 8'h30; mem[a+1] = 8'($urandom); end
        3: begin mem[a] = 8'h40; mem[a+1] = 8'($urandom); end
        4, 5: begin
          mem[a] = (k == 4) ? 8'h50 : 8'h60;
          mem[a+1] = 8'(a + 2 + 2 * int'($urandom % ((last - a) / 2)));
        end
        default: begin mem[a] = unk[$urandom % 4]; mem[a+1] = 8'($urandom); end
      endcase
      a += 2;
    end
    mem[last] = 8'h70; mem[last+1] = 8'h00;
  endtask

  initial begin
    void'($urandom(32'd20231));

    // Directed: single-step through INC then HALT.
    clearMem();
    mem[0] = 8'h30; mem[2] = 8'h70;
    stepMode = 1'b1;
    doReset();
    chk("R1 pc after reset", dbgPc, 0);
    chk("R1 acc after reset", dbgAcc, 0);
    chk("R1 halted after reset", halted, 0);
    chk("R1 address after reset", memAddr, 0);
    pulse();
    chk("R2 pc after opcode capture", dbgPc, 0);
    pulse();
    chk("R2 pc after first increment", dbgPc, 1);
    pulse(); pulse();
    chk("R2 pc after fetch", dbgPc, 2);
    repeat (5) @(negedge clk);
    chk("R10 pc held without pulse", dbgPc, 2);
    chk("R10 acc held without pulse", dbgAcc, 0);
    pulse();
    chk("R5 increment in step mode", dbgAcc, 1);
    repeat (4) pulse();
    chk("R8 pc after halt fetch", dbgPc, 4);
    chk("R8 acc on bus in first halt step", dbgBus, 1);
    pulse();
    chk("R8 not halted before stop step", halted, 0);
    pulse();
    chk("R8 halted after stop step", halted, 1);
    repeat (3) pulse();
    stepMode = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 pc frozen while halted", dbgPc, 4);
    chk("R8 still halted", halted, 1);

    // Directed: wrap, store, zero jump both ways, unknown opcode, jump.
    clearMem();
    mem[8'h80] = 8'hFF;
    mem[8'h00] = 8'h10; mem[8'h01] = 8'h80;
    mem[8'h02] = 8'h30;
    mem[8'h04] = 8'h20; mem[8'h05] = 8'h81;
    mem[8'h06] = 8'h40;
    mem[8'h08] = 8'h20; mem[8'h09] = 8'h82;
    mem[8'h0A] = 8'h60; mem[8'h0B] = 8'h20;
    mem[8'h0C] = 8'h90;
    mem[8'h0E] = 8'h10; mem[8'h0F] = 8'h81;
    mem[8'h10] = 8'h60; mem[8'h11] = 8'h20;
    mem[8'h12] = 8'h30;
    mem[8'h20] = 8'h50; mem[8'h21] = 8'h24;
    mem[8'h22] = 8'h30;
    mem[8'h24] = 8'h70;
    mem[8'h81] = 8'h55; mem[8'h82] = 8'h55;
    runAndCompare("directed");
    chk("R5 FFh plus one stored", mem[8'h81], 8'h00);
    chk("R5 00h minus one stored", mem[8'h82], 8'hFF);
    chk("R7 R9 micro-steps with unknown opcode and both zero-jumps", refSteps, 55);
    chk("R7 taken zero-jump leaves acc zero", dbgAcc, 8'h00);
    chk("R6 pc after jump and halt", dbgPc, 8'h26);

    // Random programs.
    for (int t = 0; t < 40; t++) begin
      buildRandom();
      runAndCompare("random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R2 actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule